// File: doc/BRIEF.md
# Polyphase Scaler Control and Coefficient Register Block

This block is the memory-mapped control slave of a polyphase video scaler. A host reaches it over a simple word-addressed register bus that carries address, write strobe, write data, read strobe and read data. Through it the host starts and stops the scaler, sets the size of the next output frame, and loads filter coefficients for the horizontal and vertical filters.

Coefficients are loaded indirectly. The host first writes one value per tap into a shared set of staging registers. It then writes a phase number to the horizontal or the vertical phase register. That write copies every staged tap into the coefficient storage for that direction, at the phase written and in the bank named by that direction's write-bank register. Each direction has a read-bank select that is separate from its write-bank select. The host can therefore fill one bank while the datapath filters from another.

The datapath marks each frame boundary with a start strobe and each frame end with a done strobe. When a start strobe arrives while the run bit is set, the block copies the programmed size and both read-bank selects into active registers and reports itself busy. It stays busy until the done strobe. The datapath reads coefficients through combinational ports indexed by phase and tap, and these ports always use the active read bank.

Top module: `scl_ctrl_regs`

## Requirements
- R1: After synchronous reset every register reads 0, `busy` is 0, the active width and height are 0, and both coefficient read ports return 0.
- R2: Writes to word addresses 0 (run bit in bit 0), 3 (width, 16 bits), 4 (height, 16 bits), 5/6 (horizontal write/read bank), 7/8 (vertical write/read bank) and 11 to 10+NTAPS (staged taps, COEF_W bits each) are read back unchanged, masked to the field width. Read data appears one cycle after the read strobe.
- R3: Address 2 reads 0, and so does every bit above a field's width. Writes to address 2 and to address 1 (status) have no effect.
- R4: A frame-start strobe while the run bit is 1 makes `busy` 1 and loads the active width, height and both active read banks from their programmed registers on the same clock edge. Address 1 bit 0 then reads 1.
- R5: A frame-start strobe while the run bit is 0 leaves `busy` at 0 and leaves all active values unchanged.
- R6: Clearing the run bit during a frame does not drop `busy`. A frame-done strobe with no start strobe in the same cycle clears `busy` on that edge.
- R7: Width and height written during a frame do not change the active values until the next accepted frame-start strobe.
- R8: A write to address 9 copies all staged taps into horizontal storage at the horizontal write bank and at the phase equal to the written value.
- R9: A write to address 10 does the same for vertical storage, using the vertical write bank.
- R10: Every phase-register write commits the staged taps, even when the phase value equals the one written before.
- R11: The coefficient read ports use the active read bank only. Committing into another bank, or writing the read-bank register without an accepted frame start, does not change what the ports return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered |
| frame_start | input | 1 | Datapath frame-boundary strobe |
| frame_done | input | 1 | Datapath end-of-frame strobe |
| busy | output | 1 | Frame in progress |
| act_width | output | 16 | Active output width |
| act_height | output | 16 | Active output height |
| h_rd_phase | input | PH_W | Horizontal read phase |
| h_rd_tap | input | TAP_W | Horizontal read tap |
| h_rd_coef | output | COEF_W | Horizontal coefficient |
| v_rd_phase | input | PH_W | Vertical read phase |
| v_rd_tap | input | TAP_W | Vertical read tap |
| v_rd_coef | output | COEF_W | Vertical coefficient |

## Verification
Register read data is due one clock after the edge that samples the read strobe. `busy` and the active size and banks change on the edge that samples a frame strobe. A committed coefficient shows on the read port right after the edge that samples the phase write, because the port is combinational. The bench drives every strobe for one full cycle starting at a falling edge and samples results at the following falling edge, or 1 ns after the read indices change. Each result is therefore read exactly one register stage after its cause.

// File: rtl/scl_pkg.sv
package scl_pkg;

    localparam int BUS_W = 32;
    localparam int DIM_W = 16;

    // Word addresses; the tap window starts at A_TAP0
    localparam int A_CTRL = 0;
    localparam int A_STAT = 1;
    localparam int A_RSVD = 2;
    localparam int A_WID  = 3;
    localparam int A_HGT  = 4;
    localparam int A_HWB  = 5;
    localparam int A_HRB  = 6;
    localparam int A_VWB  = 7;
    localparam int A_VRB  = 8;
    localparam int A_HPH  = 9;
    localparam int A_VPH  = 10;
    localparam int A_TAP0 = 11;

    typedef struct packed {
        logic [DIM_W-1:0] width;
        logic [DIM_W-1:0] height;
    } frame_dim_t;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/scl_coef_store.sv
module scl_coef_store
    import scl_pkg::*;
#(
    parameter int NTAPS   = 4,
    parameter int NPHASES = 8,
    parameter int NBANKS  = 2,
    parameter int COEF_W  = 16,
    localparam int BANK_W = idx_w(NBANKS),
    localparam int PH_W   = idx_w(NPHASES),
    localparam int TAP_W  = idx_w(NTAPS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           commit,
    input  logic [BANK_W-1:0]              wbank,
    input  logic [PH_W-1:0]                wphase,
    input  logic [NTAPS-1:0][COEF_W-1:0]   wtaps,
    input  logic [BANK_W-1:0]              rbank,
    input  logic [PH_W-1:0]                rphase,
    input  logic [TAP_W-1:0]               rtap,
    output logic [COEF_W-1:0]              rcoef
);

    localparam int NENT = NBANKS * NPHASES;

    logic [NTAPS-1:0][COEF_W-1:0] ent_flat [NENT];

    for (genvar gb = 0; gb < NBANKS; gb++) begin : g_bank
        for (genvar gp = 0; gp < NPHASES; gp++) begin : g_phase
            logic [NTAPS-1:0][COEF_W-1:0] ent_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    ent_q <= '0;
                end else if (commit && int'(wbank) == gb && int'(wphase) == gp) begin
                    ent_q <= wtaps;
                end
            end
            assign ent_flat[gb*NPHASES + gp] = ent_q;
        end
    end

    always_comb begin
        int idx;
        idx   = int'(rbank) * NPHASES + int'(rphase);
        rcoef = '0;
        if (int'(rbank) < NBANKS && int'(rphase) < NPHASES && int'(rtap) < NTAPS) begin
            rcoef = ent_flat[idx][rtap];
        end
    end

endmodule

// File: rtl/scl_frame_ctl.sv
module scl_frame_ctl
    import scl_pkg::*;
#(
    parameter int BANK_W = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_done,
    input  logic              run,
    input  frame_dim_t        nxt_dim,
    input  logic [BANK_W-1:0] nxt_hrb,
    input  logic [BANK_W-1:0] nxt_vrb,
    output logic              busy,
    output frame_dim_t        act_dim,
    output logic [BANK_W-1:0] act_hrb,
    output logic [BANK_W-1:0] act_vrb
);

    logic accept;
    assign accept = frame_start && run;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            act_dim <= '0;
            act_hrb <= '0;
            act_vrb <= '0;
        end else begin
            if (accept) begin
                busy    <= 1'b1;
                act_dim <= nxt_dim;
                act_hrb <= nxt_hrb;
                act_vrb <= nxt_vrb;
            end else if (frame_done) begin
                busy <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/scl_ctrl_regs.sv
module scl_ctrl_regs
    import scl_pkg::*;
#(
    parameter int NTAPS   = 4,
    parameter int NPHASES = 8,
    parameter int NBANKS  = 2,
    parameter int COEF_W  = 16,
    parameter int ADDR_W  = 5,
    localparam int BANK_W = idx_w(NBANKS),
    localparam int PH_W   = idx_w(NPHASES),
    localparam int TAP_W  = idx_w(NTAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_rd,
    output logic [31:0]       bus_rdata,
    input  logic              frame_start,
    input  logic              frame_done,
    output logic              busy,
    output logic [15:0]       act_width,
    output logic [15:0]       act_height,
    input  logic [PH_W-1:0]   h_rd_phase,
    input  logic [TAP_W-1:0]  h_rd_tap,
    output logic [COEF_W-1:0] h_rd_coef,
    input  logic [PH_W-1:0]   v_rd_phase,
    input  logic [TAP_W-1:0]  v_rd_tap,
    output logic [COEF_W-1:0] v_rd_coef
);

    int                           addr_i;
    logic                         go_q;
    frame_dim_t                   nxt_dim;
    frame_dim_t                   act_dim;
    logic [BANK_W-1:0]            hwb_q, hrb_q, vwb_q, vrb_q;
    logic [BANK_W-1:0]            act_hrb, act_vrb;
    logic [PH_W-1:0]              hph_q, vph_q;
    logic [NTAPS-1:0][COEF_W-1:0] stage_q;
    logic                         h_commit, v_commit;
    logic [31:0]                  rd_mux;
    logic                         wdata_unused;

    assign addr_i       = int'(bus_addr);
    assign wdata_unused = ^bus_wdata;

    // Writable registers; status and reserved addresses fall to default
    always_ff @(posedge clk) begin
        if (rst) begin
            go_q    <= 1'b0;
            nxt_dim <= '0;
            hwb_q   <= '0;
            hrb_q   <= '0;
            vwb_q   <= '0;
            vrb_q   <= '0;
            hph_q   <= '0;
            vph_q   <= '0;
            stage_q <= '0;
        end else if (bus_wr) begin
            case (addr_i)
                A_CTRL: go_q           <= bus_wdata[0];
                A_WID:  nxt_dim.width  <= bus_wdata[DIM_W-1:0];
                A_HGT:  nxt_dim.height <= bus_wdata[DIM_W-1:0];
                A_HWB:  hwb_q          <= bus_wdata[BANK_W-1:0];
                A_HRB:  hrb_q          <= bus_wdata[BANK_W-1:0];
                A_VWB:  vwb_q          <= bus_wdata[BANK_W-1:0];
                A_VRB:  vrb_q          <= bus_wdata[BANK_W-1:0];
                A_HPH:  hph_q          <= bus_wdata[PH_W-1:0];
                A_VPH:  vph_q          <= bus_wdata[PH_W-1:0];
                default: begin
                    for (int t = 0; t < NTAPS; t++) begin
                        if (addr_i == A_TAP0 + t) stage_q[t] <= bus_wdata[COEF_W-1:0];
                    end
                end
            endcase
        end
    end

    // Every phase write commits, whatever value it carries
    assign h_commit = bus_wr && (addr_i == A_HPH);
    assign v_commit = bus_wr && (addr_i == A_VPH);

    always_comb begin
        rd_mux = '0;
        case (addr_i)
            A_CTRL: rd_mux = 32'(go_q);
            A_STAT: rd_mux = 32'(busy);
            A_WID:  rd_mux = 32'(nxt_dim.width);
            A_HGT:  rd_mux = 32'(nxt_dim.height);
            A_HWB:  rd_mux = 32'(hwb_q);
            A_HRB:  rd_mux = 32'(hrb_q);
            A_VWB:  rd_mux = 32'(vwb_q);
            A_VRB:  rd_mux = 32'(vrb_q);
            A_HPH:  rd_mux = 32'(hph_q);
            A_VPH:  rd_mux = 32'(vph_q);
            default: begin
                for (int t = 0; t < NTAPS; t++) begin
                    if (addr_i == A_TAP0 + t) rd_mux = 32'(stage_q[t]);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    scl_frame_ctl #(.BANK_W(BANK_W)) u_frame (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .frame_done  (frame_done),
        .run         (go_q),
        .nxt_dim     (nxt_dim),
        .nxt_hrb     (hrb_q),
        .nxt_vrb     (vrb_q),
        .busy        (busy),
        .act_dim     (act_dim),
        .act_hrb     (act_hrb),
        .act_vrb     (act_vrb)
    );

    assign act_width  = act_dim.width;
    assign act_height = act_dim.height;

    scl_coef_store #(
        .NTAPS(NTAPS), .NPHASES(NPHASES), .NBANKS(NBANKS), .COEF_W(COEF_W)
    ) u_hstore (
        .clk    (clk),
        .rst    (rst),
        .commit (h_commit),
        .wbank  (hwb_q),
        .wphase (bus_wdata[PH_W-1:0]),
        .wtaps  (stage_q),
        .rbank  (act_hrb),
        .rphase (h_rd_phase),
        .rtap   (h_rd_tap),
        .rcoef  (h_rd_coef)
    );

    scl_coef_store #(
        .NTAPS(NTAPS), .NPHASES(NPHASES), .NBANKS(NBANKS), .COEF_W(COEF_W)
    ) u_vstore (
        .clk    (clk),
        .rst    (rst),
        .commit (v_commit),
        .wbank  (vwb_q),
        .wphase (bus_wdata[PH_W-1:0]),
        .wtaps  (stage_q),
        .rbank  (act_vrb),
        .rphase (v_rd_phase),
        .rtap   (v_rd_tap),
        .rcoef  (v_rd_coef)
    );

endmodule

// File: rtl/scl_ctrl_regs_chk.sv
module scl_ctrl_regs_chk #(
    parameter int ADDR_W = 5,
    parameter int BANK_W = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_start,
    input logic              frame_done,
    input logic              go_q,
    input logic              busy,
    input logic              bus_rd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic [15:0]       act_width,
    input logic [15:0]       act_height,
    input logic [BANK_W-1:0] act_hrb,
    input logic [BANK_W-1:0] act_vrb
);

    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
        (frame_start && go_q) |=> busy); // R4

    AST_STOPPED_NO_START: assert property (@(posedge clk) disable iff (rst)
        (frame_start && !go_q && !busy && !frame_done) |=> !busy); // R5

    AST_BUSY_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !frame_done) |=> busy); // R6

    AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (frame_done && !frame_start) |=> !busy); // R6

    AST_DIM_HELD: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && go_q) |=> ($stable(act_width) && $stable(act_height))); // R7

    AST_RBANK_HELD: assert property (@(posedge clk) disable iff (rst)
        !(frame_start && go_q) |=> ($stable(act_hrb) && $stable(act_vrb))); // R11

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && int'(bus_addr) == 2) |=> (bus_rdata == 32'd0)); // R3

    AST_STATUS_BIT: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && int'(bus_addr) == 1) |=> (bus_rdata == {31'd0, $past(busy)})); // R4

endmodule

bind scl_ctrl_regs scl_ctrl_regs_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .go_q        (go_q),
    .busy        (busy),
    .bus_rd      (bus_rd),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .act_width   (act_width),
    .act_height  (act_height),
    .act_hrb     (act_hrb),
    .act_vrb     (act_vrb)
);

// File: tb/scl_ctrl_regs_tb.sv
module scl_ctrl_regs_tb;

    localparam int NT = 4;
    localparam int NP = 8;
    localparam int NB = 2;
    localparam int CW = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        frame_start = 1'b0;
    logic        frame_done = 1'b0;
    logic        busy;
    logic [15:0] act_width, act_height;
    logic [2:0]  h_rd_phase = '0, v_rd_phase = '0;
    logic [1:0]  h_rd_tap = '0, v_rd_tap = '0;
    logic [CW-1:0] h_rd_coef, v_rd_coef;

    int checks = 0;
    int fails  = 0;
    logic [CW-1:0] hm [NB][NP][NT];
    logic [CW-1:0] vm [NB][NP][NT];

    always #2 clk = ~clk;

    scl_ctrl_regs u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .frame_start(frame_start), .frame_done(frame_done), .busy(busy),
        .act_width(act_width), .act_height(act_height),
        .h_rd_phase(h_rd_phase), .h_rd_tap(h_rd_tap), .h_rd_coef(h_rd_coef),
        .v_rd_phase(v_rd_phase), .v_rd_tap(v_rd_tap), .v_rd_coef(v_rd_coef)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = 5'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1;
        @(negedge clk); frame_start = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk); frame_done = 1'b1;
        @(negedge clk); frame_done = 1'b0;
    endtask

    function automatic logic [CW-1:0] exp_coef(input logic vdir, input int b, input int p, input int t);
        return vdir ? vm[b][p][t] : hm[b][p][t];
    endfunction

    task automatic load(input logic vdir, input int b, input int p, input logic [CW-1:0] taps [NT]);
        for (int t = 0; t < NT; t++) wr(11 + t, 32'(taps[t]));
        wr(vdir ? 7 : 5, 32'(b));
        wr(vdir ? 10 : 9, 32'(p));
        for (int t = 0; t < NT; t++) begin
            if (vdir) vm[b][p][t] = taps[t];
            else      hm[b][p][t] = taps[t];
        end
    endtask

    task automatic probe(input string req, input int hb, input int vb);
        for (int p = 0; p < NP; p++) begin
            for (int t = 0; t < NT; t++) begin
                h_rd_phase = 3'(p); h_rd_tap = 2'(t);
                v_rd_phase = 3'(p); v_rd_tap = 2'(t);
                #1;
                chk(req, 32'(h_rd_coef), 32'(exp_coef(1'b0, hb, p, t)));
                chk(req, 32'(v_rd_coef), 32'(exp_coef(1'b1, vb, p, t)));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [CW-1:0] taps [NT];
        void'($urandom(32'hC0EF_1234));
        for (int b = 0; b < NB; b++)
            for (int p = 0; p < NP; p++)
                for (int t = 0; t < NT; t++) begin
                    hm[b][p][t] = '0; vm[b][p][t] = '0;
                end

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 busy", 32'(busy), 0);
        chk("R1 width", 32'(act_width), 0);
        chk("R1 height", 32'(act_height), 0);
        #1 chk("R1 hcoef", 32'(h_rd_coef), 0);
        chk("R1 vcoef", 32'(v_rd_coef), 0);
        rd(0, d);  chk("R1 ctrl", d, 0);
        rd(3, d);  chk("R1 wreg", d, 0);
        rd(11, d); chk("R1 tap", d, 0);

        // R2: readback with field masking
        wr(3, 32'hABCD_0280); rd(3, d); chk("R2 width", d, 32'h0280);
        wr(4, 32'h0000_01E0); rd(4, d); chk("R2 height", d, 32'h01E0);
        wr(6, 32'h3);         rd(6, d); chk("R2 hrbank", d, 1);
        wr(8, 32'h0);         rd(8, d); chk("R2 vrbank", d, 0);
        for (int t = 0; t < NT; t++) begin
            logic [31:0] v;
            v = $urandom;
            wr(11 + t, v); rd(11 + t, d); chk("R2 tap", d, 32'(v[CW-1:0]));
        end
        wr(6, 0);

        // R3: reserved, status writes, unused bits
        wr(2, 32'h5555_5555); rd(2, d); chk("R3 rsvd", d, 0);
        wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R3 status write", d, 0);
        chk("R3 busy", 32'(busy), 0);
        wr(0, 32'hFFFF_FFFE); rd(0, d); chk("R3 ctrl bit0 only", d, 0);

        // R5: start while stopped
        pulse_start();
        chk("R5 busy", 32'(busy), 0);
        chk("R5 width", 32'(act_width), 0);

        // R4: accepted start
        wr(0, 1);
        pulse_start();
        chk("R4 busy", 32'(busy), 1);
        chk("R4 width", 32'(act_width), 32'h0280);
        chk("R4 height", 32'(act_height), 32'h01E0);
        rd(1, d); chk("R4 status", d, 1);

        // R7: mid-frame size write; R6: stop mid-frame
        wr(3, 800); wr(4, 600);
        chk("R7 width held", 32'(act_width), 32'h0280);
        chk("R7 height held", 32'(act_height), 32'h01E0);
        wr(0, 0);
        chk("R6 busy held", 32'(busy), 1);
        rd(1, d); chk("R6 status held", d, 1);
        pulse_done();
        chk("R6 busy cleared", 32'(busy), 0);
        rd(1, d); chk("R6 status cleared", d, 0);
        pulse_start();
        chk("R5 stopped width", 32'(act_width), 32'h0280);
        chk("R5 stopped busy", 32'(busy), 0);
        wr(0, 1);
        pulse_start();
        chk("R7 width next frame", 32'(act_width), 800);
        chk("R7 height next frame", 32'(act_height), 600);
        pulse_done();

        // R8, R9: random loads, then check every bank
        for (int i = 0; i < 24; i++) begin
            for (int t = 0; t < NT; t++) taps[t] = CW'($urandom);
            load(1'($urandom), int'($urandom % NB), int'($urandom % NP), taps);
        end
        for (int b = 0; b < NB; b++) begin
            wr(6, b); wr(8, NB - 1 - b);
            pulse_start(); pulse_done();
            probe("R8 R9 bank contents", b, NB - 1 - b);
        end

        // R10: same phase written twice commits twice
        wr(6, 0); wr(8, 0); pulse_start(); pulse_done();
        for (int t = 0; t < NT; t++) taps[t] = CW'(16'h1100 + t);
        load(1'b0, 0, 3, taps);
        for (int t = 0; t < NT; t++) wr(11 + t, 32'h2200 + t);
        wr(9, 3);
        h_rd_phase = 3'd3;
        for (int t = 0; t < NT; t++) begin
            h_rd_tap = 2'(t); #1;
            chk("R10 recommit", 32'(h_rd_coef), 32'h2200 + t);
            hm[0][3][t] = CW'(16'h2200 + t);
        end
        wr(7, 0); wr(10, 3);
        v_rd_phase = 3'd3;
        for (int t = 0; t < NT; t++) begin
            v_rd_tap = 2'(t); #1;
            chk("R10 R9 vertical recommit", 32'(v_rd_coef), 32'h2200 + t);
            vm[0][3][t] = CW'(16'h2200 + t);
        end

        // R11: load bank 1 while bank 0 active
        for (int t = 0; t < NT; t++) taps[t] = CW'(16'h7700 + t);
        load(1'b0, 1, 5, taps);
        wr(6, 1);
        h_rd_phase = 3'd5; h_rd_tap = 2'd2; #1;
        chk("R11 inactive bank unseen", 32'(h_rd_coef), 32'(hm[0][5][2]));
        pulse_start();
        #1 chk("R11 bank after start", 32'(h_rd_coef), 32'h7702);
        pulse_done();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule